// File: doc/BRIEF.md
# Fractional and Integer 8x8 Multiply Unit

This unit computes the 16-bit product of two 8-bit register operands for a small 8-bit processor core. Each request names a mode and the indices of the two source registers, together with their values. The unit checks that both indices fall in the window that the mode permits. It forms the product with the operand signedness that the mode selects, and in the fractional modes it doubles the product. It also produces the zero and carry flags that the multiply updates. The lower byte of the result is meant for register 0 and the upper byte for register 1.

The result is registered. A request sampled with `in_valid` at a rising clock edge is answered on the outputs right after that edge, so the latency is exactly one clock. A request with an out-of-window index or a reserved mode code returns an illegal-operand pulse instead of a write. The result and flag outputs then keep the values of the last legal operation.

Top module: `fmul_unit`

## Requirements
- R1: A synchronous active-low reset clears `res_valid`, `wr_en`, `illegal`, `res_lo`, `res_hi`, `flag_z` and `flag_c` to 0. While reset is held, requests are ignored.
- R2: A request sampled with `in_valid`=1 at a rising edge gives `res_valid`=1 for the clock that follows, with its result on the outputs. A clock without `in_valid` gives `res_valid`=0, `wr_en`=0 and `illegal`=0, and the result and flags stay unchanged.
- R3: Mode code 0 (integer, unsigned times unsigned) accepts any register index 0 to 31 for both operands and yields the unsigned product.
- R4: Mode code 1 (integer, signed times signed) takes both values as two's complement. It accepts only indices 16 to 31 for both operands.
- R5: Mode code 2 (integer, mixed) takes `rd_val` as signed and `rr_val` as unsigned. It accepts only indices 16 to 23 for both operands.
- R6: Mode codes 3, 4 and 5 are the fractional forms of codes 0, 1 and 2 with the same signedness. The result is the 16-bit product shifted left by one, with bit 0 cleared. Only indices 16 to 23 are accepted.
- R7: `flag_z` is 1 exactly when the 16-bit result, after any shift, is zero.
- R8: `flag_c` is bit 15 of the product before the fractional shift. In the integer modes this equals bit 15 of the result.
- R9: An index outside the mode's window, or mode code 6 or 7, gives `illegal`=1 and `wr_en`=0. In that case `res_lo`, `res_hi`, `flag_z` and `flag_c` keep their previous values.
- R10: A legal request gives `wr_en`=1, with result bits 7:0 on `res_lo` (for register 0) and bits 15:8 on `res_hi` (for register 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Multiply mode code (0..5, 6 and 7 reserved) |
| rd_idx | input | 5 | Index of the destination-field register |
| rr_idx | input | 5 | Index of the source-field register |
| rd_val | input | 8 | Value of the destination-field register |
| rr_val | input | 8 | Value of the source-field register |
| res_valid | output | 1 | Result pulse, one clock after the request |
| wr_en | output | 1 | Write the result pair and flags |
| illegal | output | 1 | Request rejected for operand index or mode |
| res_lo | output | 8 | Result bits 7:0, for register 0 |
| res_hi | output | 8 | Result bits 15:8, for register 1 |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The only state is the output stage, and it is visible at the ports in the clock after each request. A wrong sign-extension choice, a missing shift or a carry taken after the shift therefore shows up as a wrong `res_hi`/`res_lo`/`flag_c` in that very clock. A stage that updates on a rejected request is caught either one clock later, by the illegal pulse, or in the following idle clock, because the outputs no longer match the last legal result. The corner values are chosen so that each mistake changes a bit: -128 times -128, an all-ones mixed product, and a fractional product whose top bit is shifted out.

// File: rtl/fmul_pkg.sv
// Shared mode codes and per-mode decode helpers for the multiply unit.
// Assumes a 3-bit mode field; codes 6 and 7 are reserved and rejected.
package fmul_pkg;

    typedef enum logic [2:0] {
        MM_UU  = 3'd0,
        MM_SS  = 3'd1,
        MM_SU  = 3'd2,
        MM_FUU = 3'd3,
        MM_FSS = 3'd4,
        MM_FSU = 3'd5,
        MM_RS6 = 3'd6,
        MM_RS7 = 3'd7
    } mul_mode_e;

    typedef enum logic [1:0] {
        WIN_ALL   = 2'd0,
        WIN_UPPER = 2'd1,
        WIN_MID   = 2'd2,
        WIN_NONE  = 2'd3
    } idx_win_e;

    // Register window permitted for a mode.
    function automatic idx_win_e win_of(mul_mode_e m);
        case (m)
            MM_UU:                          return WIN_ALL;
            MM_SS:                          return WIN_UPPER;
            MM_SU, MM_FUU, MM_FSS, MM_FSU:  return WIN_MID;
            default:                        return WIN_NONE;
        endcase
    endfunction

    // True for the doubling (fractional) modes.
    function automatic logic is_frac(mul_mode_e m);
        return (m == MM_FUU) || (m == MM_FSS) || (m == MM_FSU);
    endfunction

    // Signedness of the destination-field operand.
    function automatic logic a_is_signed(mul_mode_e m);
        return (m == MM_SS) || (m == MM_SU) || (m == MM_FSS) || (m == MM_FSU);
    endfunction

    // Signedness of the source-field operand.
    function automatic logic b_is_signed(mul_mode_e m);
        return (m == MM_SS) || (m == MM_FSS);
    endfunction

endpackage

// File: rtl/fmul_opcheck.sv
// Operand index check: decides whether both register indices lie in the
// window the mode permits. Purely combinational; assumes the window bounds
// fit inside the index range.
module fmul_opcheck
    import fmul_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int UPPER_BASE = 16,
    parameter int MID_TOP    = 23
) (
    input  logic [2:0]       mode,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rr_idx,
    output logic             legal
);
    localparam int IDX_MAX = (1 << IDX_W) - 1;
    localparam int N_OPS   = 2;

    idx_win_e         win;
    logic [N_OPS-1:0] ok;
    logic [IDX_W-1:0] idx [N_OPS];

    assign idx[0] = rd_idx;
    assign idx[1] = rr_idx;

    // Window of the current mode.
    always_comb win = win_of(mul_mode_e'(mode));

    // One bound comparator per operand.
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic [IDX_W:0] lo_b, hi_b, ix;
        // Select the bounds for this operand's window and compare.
        always_comb begin
            ix = {1'b0, idx[g]};
            case (win)
                WIN_ALL:   begin lo_b = '0;                         hi_b = (IDX_W+1)'(IDX_MAX); end
                WIN_UPPER: begin lo_b = (IDX_W+1)'(UPPER_BASE);     hi_b = (IDX_W+1)'(IDX_MAX); end
                WIN_MID:   begin lo_b = (IDX_W+1)'(UPPER_BASE);     hi_b = (IDX_W+1)'(MID_TOP); end
                default:   begin lo_b = '1;                         hi_b = '0;                  end
            endcase
            ok[g] = (ix >= lo_b) && (ix <= hi_b);
        end
    end

    // Both operands must pass.
    always_comb legal = &ok;

endmodule

// File: rtl/fmul_core.sv
// Product datapath: widens each operand by one bit, signed or unsigned per
// mode, multiplies, truncates to 2*OP_W bits and applies the fractional
// doubling. Carry is the top product bit before doubling. Combinational.
module fmul_core
    import fmul_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [2:0]        mode,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] res,
    output logic              z,
    output logic              c
);
    localparam int PW = 2 * OP_W;
    localparam int EW = OP_W + 1;

    mul_mode_e             m;
    logic signed [EW-1:0]  a_ext, b_ext;
    logic signed [2*EW-1:0] full;
    logic [PW-1:0]         pre;

    assign m = mul_mode_e'(mode);

    // Sign- or zero-extend each operand as the mode dictates.
    always_comb begin
        a_ext = $signed({a_is_signed(m) & a[OP_W-1], a});
        b_ext = $signed({b_is_signed(m) & b[OP_W-1], b});
    end

    // Full signed product of the widened operands.
    always_comb full = a_ext * b_ext;

    // Truncate to the result width.
    always_comb pre = full[PW-1:0];

    // Optional doubling and the two flags.
    always_comb begin
        res = is_frac(m) ? {pre[PW-2:0], 1'b0} : pre;
        c   = pre[PW-1];
        z   = (res == '0);
    end

endmodule

// File: rtl/fmul_unit.sv
// Multiply unit top: operand index check, product datapath and a single
// output register stage (latency one clock). A rejected request pulses
// `illegal` and leaves the result and flags untouched. Synchronous
// active-low reset.
module fmul_unit
    import fmul_pkg::*;
#(
    parameter int OP_W       = 8,
    parameter int IDX_W      = 5,
    parameter int UPPER_BASE = 16,
    parameter int MID_TOP    = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       mode,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rr_idx,
    input  logic [OP_W-1:0]  rd_val,
    input  logic [OP_W-1:0]  rr_val,
    output logic             res_valid,
    output logic             wr_en,
    output logic             illegal,
    output logic [OP_W-1:0]  res_lo,
    output logic [OP_W-1:0]  res_hi,
    output logic             flag_z,
    output logic             flag_c
);
    localparam int PW = 2 * OP_W;

    logic          legal;
    logic [PW-1:0] prod;
    logic          pz, pc;
    logic          accept;

    fmul_opcheck #(
        .IDX_W      (IDX_W),
        .UPPER_BASE (UPPER_BASE),
        .MID_TOP    (MID_TOP)
    ) u_chk (
        .mode   (mode),
        .rd_idx (rd_idx),
        .rr_idx (rr_idx),
        .legal  (legal)
    );

    fmul_core #(
        .OP_W (OP_W)
    ) u_core (
        .mode (mode),
        .a    (rd_val),
        .b    (rr_val),
        .res  (prod),
        .z    (pz),
        .c    (pc)
    );

    // A request is written only when it passes the index check.
    assign accept = in_valid && legal;

    // Strobe register: valid, write and reject pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            wr_en     <= accept;
            illegal   <= in_valid && !legal;
        end
    end

    // Result and flag register, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else if (accept) begin
            res_lo <= prod[OP_W-1:0];
            res_hi <= prod[PW-1:OP_W];
            flag_z <= pz;
            flag_c <= pc;
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !wr_en && !illegal));

    // R9
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && $stable({res_hi, res_lo, flag_z, flag_c})));

    // R4
    ss_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd1 && int'(rd_idx) < UPPER_BASE) |=> illegal);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (flag_z == ({res_hi, res_lo} == '0)));

    // R3
    uu_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0) |=> wr_en);

endmodule

// File: tb/sim_fmul_unit.sv
module sim_fmul_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] mode = '0;
    logic [4:0] rd_idx = '0, rr_idx = '0;
    logic [7:0] rd_val = '0, rr_val = '0;
    logic       res_valid, wr_en, illegal, flag_z, flag_c;
    logic [7:0] res_lo, res_hi;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .rd_idx(rd_idx), .rr_idx(rr_idx), .rd_val(rd_val), .rr_val(rr_val),
        .res_valid(res_valid), .wr_en(wr_en), .illegal(illegal),
        .res_lo(res_lo), .res_hi(res_hi), .flag_z(flag_z), .flag_c(flag_c)
    );

    // {mode, rd_idx, rr_idx, rd_val, rr_val, exp_res, exp_z, exp_c, exp_ill}
    localparam int NV = 17;
    localparam logic [47:0] VEC [NV] = '{
        {3'd0, 5'd0,  5'd31, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1, 1'b0}, // R3 R8
        {3'd0, 5'd5,  5'd9,  8'h00, 8'h37, 16'h0000, 1'b1, 1'b0, 1'b0}, // R3 R7
        {3'd1, 5'd16, 5'd31, 8'hFF, 8'h02, 16'hFFFE, 1'b0, 1'b1, 1'b0}, // R4
        {3'd1, 5'd20, 5'd17, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0, 1'b0}, // R4
        {3'd2, 5'd16, 5'd23, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1, 1'b0}, // R5
        {3'd2, 5'd18, 5'd19, 8'h02, 8'h80, 16'h0100, 1'b0, 1'b0, 1'b0}, // R5
        {3'd3, 5'd16, 5'd17, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0, 1'b0}, // R6 R8
        {3'd3, 5'd22, 5'd23, 8'hFF, 8'hFF, 16'hFC02, 1'b0, 1'b1, 1'b0}, // R6
        {3'd4, 5'd16, 5'd16, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0, 1'b0}, // R6
        {3'd4, 5'd21, 5'd17, 8'h40, 8'hC0, 16'hE000, 1'b0, 1'b1, 1'b0}, // R6
        {3'd5, 5'd19, 5'd20, 8'h80, 8'hFF, 16'h0100, 1'b0, 1'b1, 1'b0}, // R6 R8
        {3'd5, 5'd17, 5'd18, 8'h7F, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0}, // R6 R7
        {3'd1, 5'd15, 5'd20, 8'h11, 8'h22, 16'h0000, 1'b0, 1'b0, 1'b1}, // R9
        {3'd2, 5'd24, 5'd16, 8'h11, 8'h22, 16'h0000, 1'b0, 1'b0, 1'b1}, // R9
        {3'd4, 5'd16, 5'd8,  8'h11, 8'h22, 16'h0000, 1'b0, 1'b0, 1'b1}, // R9
        {3'd6, 5'd16, 5'd16, 8'h11, 8'h22, 16'h0000, 1'b0, 1'b0, 1'b1}, // R9
        {3'd0, 5'd31, 5'd31, 8'h10, 8'h10, 16'h0100, 1'b0, 1'b0, 1'b0}  // R3 R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [4:0] d, input logic [4:0] r,
                         input logic [7:0] a, input logic [7:0] b);
        mode = m; rd_idx = d; rr_idx = r; rd_val = a; rr_val = b; in_valid = 1'b1;
    endtask

    logic [15:0] last_res;
    logic        last_z, last_c;

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: request during reset is ignored, outputs cleared
        @(negedge clk);
        drive(3'd0, 5'd1, 5'd2, 8'hFF, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 result", {res_hi, res_lo}, 0);
        chk("R1 flags", {flag_z, flag_c}, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        last_res = 16'h0; last_z = 1'b0; last_c = 1'b0;

        // Vector table walk, each request followed by one idle clock
        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            drive(v[47:45], v[44:40], v[39:35], v[34:27], v[26:19]);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R2 res_valid", res_valid, 1);
            chk("R9 illegal", illegal, v[0]);
            chk("R10 wr_en", wr_en, !v[0]);
            if (!v[0]) begin
                last_res = v[18:3]; last_z = v[2]; last_c = v[1];
            end
            chk("R10 res_lo", res_lo, last_res[7:0]);
            chk("R10 res_hi", res_hi, last_res[15:8]);
            chk("R7 flag_z", flag_z, last_z);
            chk("R8 flag_c", flag_c, last_c);
            rd_val = ~rd_val; rr_val = rr_val + 8'd3; mode = 3'd0;
            @(negedge clk);
            chk("R2 idle valid", {res_valid, wr_en, illegal}, 0);
            chk("R2 idle hold", {res_hi, res_lo, flag_z, flag_c}, {last_res, last_z, last_c});
        end

        // Back-to-back requests, one result per clock (R2, R4, R6)
        drive(3'd1, 5'd31, 5'd16, 8'h7F, 8'h7F);
        @(negedge clk);
        drive(3'd5, 5'd23, 5'd23, 8'hFF, 8'h01);
        chk("R4 stream first", {res_hi, res_lo}, 16'h3F01);
        chk("R2 stream valid", res_valid, 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 stream second", {res_hi, res_lo}, 16'hFFFE);
        chk("R8 stream carry", flag_c, 1);

        // Rejected request right after a legal one keeps the result (R9)
        drive(3'd7, 5'd16, 5'd16, 8'h01, 8'h01);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 reserved mode", {illegal, wr_en}, 2'b10);
        chk("R9 hold result", {res_hi, res_lo}, 16'hFFFE);

        // Reset clears a live result (R1)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid reset", {res_hi, res_lo, flag_z, flag_c, res_valid}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule